// File: doc/BRIEF.md
# Quarter-Rate Wide Word Link Bridge

The bridge moves 128-bit memory transactions between the core clock domain and an external memory board over a 32-bit link. The link runs at one quarter of the core rate and is phase-locked to it. No second clock and no crossing FIFOs are used. Instead, a counter in the core domain produces a link-enable strobe on one core cycle out of four. Every change on the link happens on that strobe, and every sample from the link is taken on it.

On the transmit side, the cache hierarchy offers a wide word with a valid/ready handshake. The bridge keeps the word in a holding register. It then puts the word on the link as four beats, starting with the lowest lane. Each beat carries its lane index, and the final beat carries a last marker.

On the receive side, the bridge collects four incoming beats into a wide register, using the index that comes with each beat. It raises a single-cycle response strobe when the word is complete. If a beat arrives with an index other than the one expected, a sticky error flag is set.

Top module: `beat_link_bridge`

## Requirements
- R1: After reset is released, `link_en_o` is high in the core cycle that follows the 3rd rising clock edge. After that it is high on exactly one core cycle in every 4 and low in the other three.
- R2: `req_ready_o` is high while the transmitter is idle. Once a word has been accepted (`req_valid_i` and `req_ready_o` both high at an edge), `req_ready_o` stays low until the strobe edge that ends the link period of the fourth beat.
- R3: Beats leave only on strobe edges, one beat per strobe, starting at the first strobe after the word is accepted. Beat i (i = 0..3) puts bits [32*i+31 : 32*i] of the word on `tx_beat_o`, with `tx_idx_o` = i and `tx_valid_o` high. The lowest lane goes first.
- R4: `tx_last_o` is high together with the index-3 beat and low for beats 0 to 2.
- R5: Between strobes, `tx_beat_o`, `tx_idx_o` and `tx_valid_o` do not change. At the strobe that follows the fourth beat, `tx_valid_o` goes low.
- R6: Receive inputs are sampled only on strobe edges. Any value on `rx_valid_i`, `rx_idx_i` or `rx_beat_i` during other cycles has no effect on the response data, the response strobe or the error flag.
- R7: A sampled beat with index i is written to lane i of the assembly register. When the beat with index 3 is sampled, `rsp_data_o` shows the assembled word and `rsp_valid_o` is high for exactly the one following core cycle. Lanes that were not written in the current word keep their earlier contents.
- R8: The expected receive index starts at 0 and becomes (received index + 1) mod 4 after each sampled beat. A sampled beat whose index differs from the expected one sets `rx_err_o`. Only reset clears it.
- R9: While `rst_ni` is low, the divider is zero, so `link_en_o` is 0. In the same state `req_ready_o` is 1, and `tx_valid_o`, `rsp_valid_o` and `rx_err_o` are 0. This holds even if reset hits in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_data_i | input | 128 | Word to transmit |
| req_valid_i | input | 1 | Transmit word offered |
| req_ready_o | output | 1 | Transmitter can take a word |
| link_en_o | output | 1 | One-in-four link strobe |
| tx_beat_o | output | 32 | Outgoing beat data |
| tx_valid_o | output | 1 | Outgoing beat valid |
| tx_idx_o | output | 2 | Lane index of outgoing beat |
| tx_last_o | output | 1 | Outgoing beat is the final lane |
| rx_beat_i | input | 32 | Incoming beat data |
| rx_valid_i | input | 1 | Incoming beat valid |
| rx_idx_i | input | 2 | Lane index of incoming beat |
| rsp_data_o | output | 128 | Reassembled response word |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rx_err_o | output | 1 | Sticky lane index error |

## Verification
Transmit and receive share one strobe. On a single strobe edge the bridge can therefore emit an outgoing beat, finish a burst so that ready is released, and complete an incoming word. The bench provokes this by running a transmit burst and a receive burst in parallel threads, both aligned to the same observed strobe. Each thread checks its own port-level results against the word computed from the pattern index. A fault that lets one path disturb the other shows up as a wrong lane, a missing response pulse or a spurious error. Junk values on the receive pins in non-strobe cycles check that the receive path ignores them even while the transmit side is busy.

// File: rtl/beat_link_pkg.sv
package beat_link_pkg;
  localparam int unsigned DEF_WORD_W = 128;
  localparam int unsigned DEF_BEAT_W = 32;
  localparam int unsigned DEF_DIV    = 4;

  function automatic int unsigned lanes_of(input int unsigned word_w, input int unsigned beat_w);
    return word_w / beat_w;
  endfunction
endpackage

// File: rtl/link_strobe_gen.sv
module link_strobe_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = (cnt_q == LAST);

  // R1: never two strobes back to back
  p_strobe_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/link_tx_serializer.sv
module link_tx_serializer #(
  parameter int unsigned WORD_W = 128,
  parameter int unsigned BEAT_W = 32
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      link_en_i,
  input  logic [WORD_W-1:0]                         req_data_i,
  input  logic                                      req_valid_i,
  output logic                                      req_ready_o,
  output logic [BEAT_W-1:0]                         beat_o,
  output logic                                      valid_o,
  output logic [$clog2(WORD_W/BEAT_W)-1:0]          idx_o,
  output logic                                      last_o
);
  localparam int unsigned BEATS = WORD_W / BEAT_W;
  localparam int unsigned IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic              busy_q, done_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] beat_q;
  logic              vld_q, last_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
      beat_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (req_valid_i) begin
        word_q <= req_data_i;
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end
    end else if (link_en_i) begin
      if (!done_q) begin
        beat_q <= word_q[int'(cnt_q)*BEAT_W +: BEAT_W];
        idx_q  <= cnt_q;
        last_q <= (cnt_q == LAST_IDX);
        vld_q  <= 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) done_q <= 1'b1;
      end else begin
        // link period of the last beat is over
        vld_q  <= 1'b0;
        last_q <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign beat_o      = beat_q;
  assign valid_o     = vld_q;
  assign idx_o       = idx_q;
  assign last_o      = last_q;

  p_accept_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && link_en_i) |=> (valid_o && idx_o == IDX_W'($past(idx_o) + 1'b1)));

  p_last_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o) |-> (idx_o == LAST_IDX));

  p_hold_between_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> ($stable(beat_o) && $stable(idx_o) && $stable(valid_o)));
endmodule

// File: rtl/link_rx_assembler.sv
module link_rx_assembler #(
  parameter int unsigned WORD_W = 128,
  parameter int unsigned BEAT_W = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               link_en_i,
  input  logic [BEAT_W-1:0]                  beat_i,
  input  logic                               valid_i,
  input  logic [$clog2(WORD_W/BEAT_W)-1:0]   idx_i,
  output logic [WORD_W-1:0]                  data_o,
  output logic                               rsp_valid_o,
  output logic                               err_o
);
  localparam int unsigned BEATS = WORD_W / BEAT_W;
  localparam int unsigned IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [WORD_W-1:0] asm_q, merged, data_q;
  logic [IDX_W-1:0]  exp_q;
  logic              rv_q, err_q;
  logic              take;

  assign take = link_en_i && valid_i;

  for (genvar l = 0; l < BEATS; l++) begin : g_lane
    assign merged[l*BEAT_W +: BEAT_W] = (idx_i == IDX_W'(l)) ? beat_i : asm_q[l*BEAT_W +: BEAT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q  <= '0;
      data_q <= '0;
      exp_q  <= '0;
      rv_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (take) begin
        asm_q <= merged;
        exp_q <= idx_i + 1'b1;
        if (idx_i != exp_q) err_q <= 1'b1;
        if (idx_i == LAST_IDX) begin
          data_q <= merged;
          rv_q   <= 1'b1;
        end
      end
    end
  end

  assign data_o      = data_q;
  assign rsp_valid_o = rv_q;
  assign err_o       = err_q;

  p_rsp_on_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(link_en_i && valid_i));

  p_rsp_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_rsp_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |=> (rsp_valid_o || $stable(data_o)));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/beat_link_bridge.sv
module beat_link_bridge
  import beat_link_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned BEAT_W = DEF_BEAT_W,
  parameter int unsigned DIV    = DEF_DIV
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [WORD_W-1:0]                       req_data_i,
  input  logic                                    req_valid_i,
  output logic                                    req_ready_o,
  output logic                                    link_en_o,
  output logic [BEAT_W-1:0]                       tx_beat_o,
  output logic                                    tx_valid_o,
  output logic [$clog2(WORD_W/BEAT_W)-1:0]        tx_idx_o,
  output logic                                    tx_last_o,
  input  logic [BEAT_W-1:0]                       rx_beat_i,
  input  logic                                    rx_valid_i,
  input  logic [$clog2(WORD_W/BEAT_W)-1:0]        rx_idx_i,
  output logic [WORD_W-1:0]                       rsp_data_o,
  output logic                                    rsp_valid_o,
  output logic                                    rx_err_o
);
  localparam int unsigned BEATS = lanes_of(WORD_W, BEAT_W);

  logic strobe;

  link_strobe_gen #(.DIV(DIV)) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_o (strobe)
  );

  link_tx_serializer #(.WORD_W(WORD_W), .BEAT_W(BEAT_W)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_en_i   (strobe),
    .req_data_i  (req_data_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .beat_o      (tx_beat_o),
    .valid_o     (tx_valid_o),
    .idx_o       (tx_idx_o),
    .last_o      (tx_last_o)
  );

  link_rx_assembler #(.WORD_W(WORD_W), .BEAT_W(BEAT_W)) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_en_i   (strobe),
    .beat_i      (rx_beat_i),
    .valid_i     (rx_valid_i),
    .idx_i       (rx_idx_i),
    .data_o      (rsp_data_o),
    .rsp_valid_o (rsp_valid_o),
    .err_o       (rx_err_o)
  );

  assign link_en_o = strobe;

  // R9: reset state observed right after release
  p_idle_after_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && !tx_valid_o && !rsp_valid_o && !rx_err_o));

  initial begin
    assert (BEATS * BEAT_W == WORD_W);
    assert (DIV >= 2);
  end
endmodule

// File: tb/test_beat_link_bridge.sv
`timescale 1ns/1ps
module test_beat_link_bridge;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic [127:0] req_data;
  logic         req_valid;
  logic         req_ready;
  logic         link_en;
  logic [31:0]  tx_beat;
  logic         tx_valid;
  logic [1:0]   tx_idx;
  logic         tx_last;
  logic [31:0]  rx_beat;
  logic         rx_valid;
  logic [1:0]   rx_idx;
  logic [127:0] rsp_data;
  logic         rsp_valid;
  logic         rx_err;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  beat_link_bridge i_beat_link_bridge (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_data_i(req_data), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .link_en_o(link_en),
    .tx_beat_o(tx_beat), .tx_valid_o(tx_valid), .tx_idx_o(tx_idx), .tx_last_o(tx_last),
    .rx_beat_i(rx_beat), .rx_valid_i(rx_valid), .rx_idx_i(rx_idx),
    .rsp_data_o(rsp_data), .rsp_valid_o(rsp_valid), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int k);
    logic [127:0] w;
    if (k == 0) return '0;
    if (k == 1) return '1;
    for (int l = 0; l < 4; l++)
      w[l*32 +: 32] = {8'(k), 8'(l + 1), 16'(k * 37 + l * 4099)};
    return w;
  endfunction

  task automatic check_reset_state(input string tag);
    chk(req_ready == 1'b1, tag, 128'(req_ready), 128'd1);
    chk(tx_valid == 1'b0, tag, 128'(tx_valid), 128'd0);
    chk(rsp_valid == 1'b0, tag, 128'(rsp_valid), 128'd0);
    chk(rx_err == 1'b0, tag, 128'(rx_err), 128'd0);
    chk(link_en == 1'b0, tag, 128'(link_en), 128'd0);
  endtask

  task automatic send_word(input logic [127:0] w);
    logic [31:0] prev;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_data  = w;
    @(negedge clk);
    req_valid = 1'b0;
    req_data  = ~w;
    chk(!req_ready, "R2 ready drops", 128'(req_ready), 128'd0);
    prev = tx_beat;
    for (int b = 0; b < 4; b++) begin
      while (!link_en) begin
        if (b > 0) chk(tx_beat == prev && tx_valid && tx_idx == 2'(b - 1), "R5 beat held",
                       128'(tx_beat), 128'(prev));
        @(negedge clk);
      end
      @(negedge clk);
      chk(tx_valid && tx_idx == 2'(b), "R3 beat index", 128'({tx_valid, tx_idx}), 128'({1'b1, 2'(b)}));
      chk(tx_beat == w[b*32 +: 32], "R3 beat lane", 128'(tx_beat), 128'(w[b*32 +: 32]));
      chk(tx_last == (b == 3), "R4 last marker", 128'(tx_last), 128'(b == 3));
      chk(!req_ready, "R2 ready low in burst", 128'(req_ready), 128'd0);
      prev = tx_beat;
    end
    while (!link_en) @(negedge clk);
    @(negedge clk);
    chk(!tx_valid, "R5 valid drops", 128'(tx_valid), 128'd0);
    chk(req_ready, "R2 ready back", 128'(req_ready), 128'd1);
  endtask

  task automatic recv_word(input logic [127:0] w, input logic [127:0] exp, input bit bad);
    int b = 0;
    int nb = bad ? 3 : 4;
    while (b < nb) begin
      @(negedge clk);
      if (link_en) begin
        int idx = (bad && b > 0) ? b + 1 : b;
        rx_valid = 1'b1;
        rx_idx   = 2'(idx);
        rx_beat  = w[idx*32 +: 32];
        b++;
      end else begin
        // junk outside the strobe (R6)
        rx_valid = 1'b1;
        rx_idx   = 2'(b + 2);
        rx_beat  = ~w[(b % 4)*32 +: 32];
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(rsp_valid, "R7 response pulse", 128'(rsp_valid), 128'd1);
    chk(rsp_data == exp, "R7 response data", rsp_data, exp);
    @(negedge clk);
    chk(!rsp_valid, "R7 single cycle", 128'(rsp_valid), 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] e;
    rst_ni = 1'b0; req_valid = 1'b0; req_data = '0;
    rx_valid = 1'b0; rx_idx = '0; rx_beat = '0;
    repeat (3) @(negedge clk);
    check_reset_state("R9 reset");
    rst_ni = 1'b1;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      chk(link_en == (j % 4 == 3), "R1 strobe cadence", 128'(link_en), 128'(j % 4 == 3));
    end

    // transmit and receive in parallel on shared strobes
    for (int k = 0; k < 6; k++) begin
      fork
        send_word(pat(k));
        recv_word(pat(k + 8), pat(k + 8), 1'b0);
      join
    end
    chk(!rx_err, "R6 junk ignored, R8 no error", 128'(rx_err), 128'd0);

    // index skip: 0,2,3 -> error, lane 1 keeps previous content
    e = pat(20);
    e[32 +: 32] = pat(13)[32 +: 32];
    recv_word(pat(20), e, 1'b1);
    chk(rx_err, "R8 error set", 128'(rx_err), 128'd1);
    recv_word(pat(21), pat(21), 1'b0);
    chk(rx_err, "R8 error sticky", 128'(rx_err), 128'd1);

    // reset during a burst
    @(negedge clk);
    req_valid = 1'b1; req_data = pat(25);
    @(negedge clk);
    req_valid = 1'b0;
    while (!tx_valid) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check_reset_state("R9 mid-burst reset");
    rst_ni = 1'b1;
    send_word(pat(30));
    recv_word(pat(31), pat(31), 1'b0);
    chk(!rx_err, "R8 clean after reset", 128'(rx_err), 128'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule